// File: doc/BRIEF.md
# Memory operation issue ordering checker

This block keeps a small table of memory operations that have been dispatched but not yet completed. Each entry records a sequence index and four flags: load, store, load barrier and store barrier. Operations enter through a dispatch port that carries increasing indices. They leave through a completion port that names the index to retire.

A separate query port takes an index and its load and store flags. It answers combinationally whether that operation may issue now. The answer depends only on age order against the oldest outstanding load, store, load barrier and store barrier. No addresses are compared, and no store buffer limit is modelled. A mode input lets loads bypass older stores, on the optimistic assumption that loads never alias stores.

Ages are compared on 8-bit indices with modular subtraction. An index `a` is older than `b` when `(b - a) mod 256` lies in 1..127, so at most 128 operations may be in flight at once. A barrier entry is dispatched with its access flag also set: a load barrier carries the load flag, and a store barrier carries the store flag.

Top module: `mem_order_check`

## Requirements
- R1: A query with neither the load nor the store flag set is always reported ready.
- R2: A queried load is not ready when a load barrier older than it is outstanding. A queried load that is itself the oldest outstanding load barrier is ready only if no outstanding load is older than it.
- R3: A queried store is not ready when a store barrier older than it is outstanding. A queried store that is itself the oldest outstanding store barrier is ready only if no outstanding store is older than it.
- R4: With bypass mode off, a query is not ready when a store older than it is outstanding. A query with both flags set must pass the rules for a load and the rules for a store.
- R5: With bypass mode on, a query with only the load flag set that passes R2 is ready, whatever older loads or stores are outstanding.
- R6: A load is never held back by older loads. A store is not ready while any load older than it is outstanding.
- R7: `disp_full` is high exactly when all NUM_ENTRIES slots are occupied. A dispatch offered while full is dropped and leaves the table unchanged.
- R8: A completion whose index matches no outstanding entry leaves the table unchanged.
- R9: Age order holds across the 255-to-0 wrap of the index: index 254 is older than index 1.
- R10: After reset the table is empty, `disp_full` is low and every query is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_mode | input | 1 | 1 lets loads ignore older stores |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | 8 | Sequence index of the dispatched operation |
| disp_ld | input | 1 | Dispatched operation reads memory |
| disp_st | input | 1 | Dispatched operation writes memory |
| disp_lbar | input | 1 | Dispatched operation is a load barrier |
| disp_sbar | input | 1 | Dispatched operation is a store barrier |
| disp_full | output | 1 | Table has no free slot; dispatch is refused |
| cmpl_valid | input | 1 | Completion request |
| cmpl_idx | input | 8 | Index of the completing operation |
| q_idx | input | 8 | Index of the queried operation |
| q_ld | input | 1 | Queried operation reads memory |
| q_st | input | 1 | Queried operation writes memory |
| q_ready | output | 1 | Queried operation may issue now |

## Verification
Every mix of one to three outstanding operations drawn from six kinds is built: plain, load, store, load plus store, load barrier and store barrier. The base index moves so that many mixes straddle the index wrap. Each outstanding entry is queried with its own flags, which tells apart the barrier-equals-oldest cases from the strictly-younger ones. A fresh younger index is queried with all four flag combinations under both modes, which tells apart load, store and combined rules and shows where bypass changes the answer. Separate sequences fill the table to check refusal, and retire absent indices to show they have no effect on readiness.

// File: rtl/mo_pkg.sv
package mo_pkg;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] seq_t;

  typedef struct packed {
    logic vld;
    seq_t idx;
    logic ld;
    logic st;
    logic lbar;
    logic sbar;
  } slot_t;

  localparam int QSEL_LOAD  = 0;
  localparam int QSEL_STORE = 1;
  localparam int QSEL_LBAR  = 2;
  localparam int QSEL_SBAR  = 3;
  localparam int NUM_QUEUES = 4;

  // a is strictly older than b under modular distance (< half range)
  function automatic logic seq_older(seq_t a, seq_t b);
    seq_t d;
    d = b - a;
    return (d != '0) && !d[IDX_W-1];
  endfunction

  // membership of a slot in one of the four ordering queues
  function automatic logic in_queue(slot_t s, int qsel);
    logic m;
    case (qsel)
      QSEL_LOAD:  m = s.ld;
      QSEL_STORE: m = s.st;
      QSEL_LBAR:  m = s.lbar;
      default:    m = s.sbar;
    endcase
    return s.vld && m;
  endfunction
endpackage

// File: rtl/mo_table.sv
module mo_table
  import mo_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  seq_t             disp_idx,
  input  logic             disp_ld,
  input  logic             disp_st,
  input  logic             disp_lbar,
  input  logic             disp_sbar,
  input  logic             cmpl_valid,
  input  seq_t             cmpl_idx,
  output slot_t [N-1:0]    slots,
  output logic             disp_full,
  output logic             disp_accept,
  output logic             cmpl_hit,
  output logic [$clog2(N+1)-1:0] occ
);
  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1;
  localparam int OCC_W  = $clog2(N+1);

  slot_t [N-1:0]    slots_q;
  logic [N-1:0]     cmpl_match;
  logic             free_found;
  logic [SLOT_W-1:0] free_slot;

  // lowest-numbered free slot
  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!slots_q[i].vld) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cmpl_match[i] = cmpl_valid && slots_q[i].vld && (slots_q[i].idx == cmpl_idx);
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < N; i++) begin
      occ = occ + OCC_W'(slots_q[i].vld);
    end
  end

  assign disp_full   = !free_found;
  assign disp_accept = disp_valid && free_found;
  assign cmpl_hit    = |cmpl_match;
  assign slots       = slots_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        slots_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cmpl_match[i]) begin
          slots_q[i].vld <= 1'b0;
        end
        if (disp_accept && (free_slot == SLOT_W'(i))) begin
          slots_q[i].vld  <= 1'b1;
          slots_q[i].idx  <= disp_idx;
          slots_q[i].ld   <= disp_ld;
          slots_q[i].st   <= disp_st;
          slots_q[i].lbar <= disp_lbar;
          slots_q[i].sbar <= disp_sbar;
        end
      end
    end
  end
endmodule

// File: rtl/mo_oldest.sv
module mo_oldest
  import mo_pkg::*;
#(
  parameter int N    = 16,
  parameter int QSEL = QSEL_LOAD
) (
  input  slot_t [N-1:0] slots,
  output logic          found,
  output seq_t          oldest
);
  // priority-minimum: walk the slots keeping the oldest member seen
  always_comb begin
    found  = 1'b0;
    oldest = '0;
    for (int i = 0; i < N; i++) begin
      if (in_queue(slots[i], QSEL)) begin
        if (!found || seq_older(slots[i].idx, oldest)) begin
          oldest = slots[i].idx;
        end
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mo_rules.sv
module mo_rules
  import mo_pkg::*;
(
  input  logic bypass_mode,
  input  seq_t q_idx,
  input  logic q_ld,
  input  logic q_st,
  input  logic ld_found,
  input  seq_t ld_oldest,
  input  logic st_found,
  input  seq_t st_oldest,
  input  logic lb_found,
  input  seq_t lb_oldest,
  input  logic sb_found,
  input  seq_t sb_oldest,
  output logic lbar_block,
  output logic sbar_block,
  output logic store_block,
  output logic load_block,
  output logic q_ready
);
  logic is_mem;
  logic bypass_hit;

  assign is_mem = q_ld || q_st;

  // load barrier gate: younger than the barrier, or the barrier itself
  // while an older load remains
  assign lbar_block = q_ld && lb_found &&
                      (seq_older(lb_oldest, q_idx) ||
                       ((q_idx == lb_oldest) && !(ld_found && (q_idx == ld_oldest))));

  assign sbar_block = q_st && sb_found &&
                      (seq_older(sb_oldest, q_idx) ||
                       ((q_idx == sb_oldest) && !(st_found && (q_idx == st_oldest))));

  assign bypass_hit  = bypass_mode && q_ld && !q_st;
  assign store_block = st_found && seq_older(st_oldest, q_idx);
  assign load_block  = q_st && ld_found && seq_older(ld_oldest, q_idx);

  always_comb begin
    if (!is_mem)                      q_ready = 1'b1;
    else if (lbar_block || sbar_block) q_ready = 1'b0;
    else if (bypass_hit)              q_ready = 1'b1;
    else if (store_block)             q_ready = 1'b0;
    else                              q_ready = !load_block;
  end
endmodule

// File: rtl/mem_order_check.sv
module mem_order_check
  import mo_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass_mode,
  input  logic       disp_valid,
  input  logic [7:0] disp_idx,
  input  logic       disp_ld,
  input  logic       disp_st,
  input  logic       disp_lbar,
  input  logic       disp_sbar,
  output logic       disp_full,
  input  logic       cmpl_valid,
  input  logic [7:0] cmpl_idx,
  input  logic [7:0] q_idx,
  input  logic       q_ld,
  input  logic       q_st,
  output logic       q_ready
);
  localparam int OCC_W = $clog2(NUM_ENTRIES+1);

  slot_t [NUM_ENTRIES-1:0] slots;
  logic                    disp_accept;
  logic                    cmpl_hit;
  logic [OCC_W-1:0]        occ;
  logic [NUM_QUEUES-1:0]   q_found;
  seq_t                    q_oldest [NUM_QUEUES];
  logic                    lbar_block, sbar_block, store_block, load_block;

  mo_table #(.N(NUM_ENTRIES)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_valid  (disp_valid),
    .disp_idx    (disp_idx),
    .disp_ld     (disp_ld),
    .disp_st     (disp_st),
    .disp_lbar   (disp_lbar),
    .disp_sbar   (disp_sbar),
    .cmpl_valid  (cmpl_valid),
    .cmpl_idx    (cmpl_idx),
    .slots       (slots),
    .disp_full   (disp_full),
    .disp_accept (disp_accept),
    .cmpl_hit    (cmpl_hit),
    .occ         (occ)
  );

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_oldest
    mo_oldest #(.N(NUM_ENTRIES), .QSEL(g)) u_old (
      .slots  (slots),
      .found  (q_found[g]),
      .oldest (q_oldest[g])
    );
  end

  mo_rules u_rules (
    .bypass_mode (bypass_mode),
    .q_idx       (q_idx),
    .q_ld        (q_ld),
    .q_st        (q_st),
    .ld_found    (q_found[QSEL_LOAD]),
    .ld_oldest   (q_oldest[QSEL_LOAD]),
    .st_found    (q_found[QSEL_STORE]),
    .st_oldest   (q_oldest[QSEL_STORE]),
    .lb_found    (q_found[QSEL_LBAR]),
    .lb_oldest   (q_oldest[QSEL_LBAR]),
    .sb_found    (q_found[QSEL_SBAR]),
    .sb_oldest   (q_oldest[QSEL_SBAR]),
    .lbar_block  (lbar_block),
    .sbar_block  (sbar_block),
    .store_block (store_block),
    .load_block  (load_block),
    .q_ready     (q_ready)
  );
endmodule

// File: rtl/mo_checker.sv
module mo_checker
  import mo_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bypass_mode,
  input logic                           disp_valid,
  input logic                           disp_full,
  input logic                           disp_accept,
  input logic                           cmpl_valid,
  input logic                           cmpl_hit,
  input logic [$clog2(NUM_ENTRIES+1)-1:0] occ,
  input logic [7:0]                     q_idx,
  input logic                           q_ld,
  input logic                           q_st,
  input logic                           q_ready,
  input logic [NUM_QUEUES-1:0]          q_found,
  input seq_t                           q_oldest [NUM_QUEUES]
);
  // R1
  a_r1_nonmem_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_ld && !q_st) |-> q_ready);

  // R2
  a_r2_lbar_younger: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ld && q_found[QSEL_LBAR] && seq_older(q_oldest[QSEL_LBAR], q_idx)) |-> !q_ready);

  // R3
  a_r3_sbar_younger: assert property (@(posedge clk) disable iff (!rst_n)
    (q_st && q_found[QSEL_SBAR] && seq_older(q_oldest[QSEL_SBAR], q_idx)) |-> !q_ready);

  // R4
  a_r4_older_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_mode && (q_ld || q_st) && q_found[QSEL_STORE] &&
     seq_older(q_oldest[QSEL_STORE], q_idx)) |-> !q_ready);

  // R5
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && q_ld && !q_st && !q_found[QSEL_LBAR]) |-> q_ready);

  // R6
  a_r6_store_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (q_st && q_found[QSEL_LOAD] && seq_older(q_oldest[QSEL_LOAD], q_idx)) |-> !q_ready);

  // R7
  a_r7_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    disp_full == (occ == NUM_ENTRIES));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_full) |=> (occ <= $past(occ)));

  // R8
  a_r8_absent_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_hit && !disp_accept) |=> (occ == $past(occ)));
endmodule

bind mem_order_check mo_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bypass_mode (bypass_mode),
  .disp_valid  (disp_valid),
  .disp_full   (disp_full),
  .disp_accept (disp_accept),
  .cmpl_valid  (cmpl_valid),
  .cmpl_hit    (cmpl_hit),
  .occ         (occ),
  .q_idx       (q_idx),
  .q_ld        (q_ld),
  .q_st        (q_st),
  .q_ready     (q_ready),
  .q_found     (q_found),
  .q_oldest    (q_oldest)
);

// File: tb/mem_order_check_test.sv
`timescale 1ns/1ps
module mem_order_check_test;
  localparam int NE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass_mode = 1'b0;
  logic       disp_valid = 1'b0;
  logic [7:0] disp_idx = '0;
  logic       disp_ld = 1'b0, disp_st = 1'b0, disp_lbar = 1'b0, disp_sbar = 1'b0;
  logic       disp_full;
  logic       cmpl_valid = 1'b0;
  logic [7:0] cmpl_idx = '0;
  logic [7:0] q_idx = '0;
  logic       q_ld = 1'b0, q_st = 1'b0;
  logic       q_ready;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // bench-side record of outstanding operations
  bit       tv [4];
  bit [7:0] ti [4];
  int       tk [4];

  mem_order_check #(.NUM_ENTRIES(NE)) uut (.*);

  always #10 clk = ~clk;

  function automatic bit older(bit [7:0] a, bit [7:0] b);
    int d;
    d = (int'(b) - int'(a) + 256) % 256;
    return (d >= 1) && (d <= 127);
  endfunction

  function automatic bit k_ld(int k);   return k == 1 || k == 3 || k == 4; endfunction
  function automatic bit k_st(int k);   return k == 2 || k == 3 || k == 5; endfunction
  function automatic bit k_lb(int k);   return k == 4; endfunction
  function automatic bit k_sb(int k);   return k == 5; endfunction

  // expected readiness restated as "does any older blocker exist"
  function automatic bit expect_ready(bit [7:0] q, bit ld, bit st, bit na, output string tag);
    tag = "R6";
    if (!ld && !st) begin tag = "R1"; return 1; end
    if (ld) begin
      for (int e = 0; e < 4; e++)
        if (tv[e] && k_lb(tk[e]) && older(ti[e], q)) begin tag = "R2"; return 0; end
      for (int e = 0; e < 4; e++)
        if (tv[e] && k_lb(tk[e]) && ti[e] == q)
          for (int f = 0; f < 4; f++)
            if (tv[f] && k_ld(tk[f]) && older(ti[f], q)) begin tag = "R2"; return 0; end
    end
    if (st) begin
      for (int e = 0; e < 4; e++)
        if (tv[e] && k_sb(tk[e]) && older(ti[e], q)) begin tag = "R3"; return 0; end
      for (int e = 0; e < 4; e++)
        if (tv[e] && k_sb(tk[e]) && ti[e] == q)
          for (int f = 0; f < 4; f++)
            if (tv[f] && k_st(tk[f]) && older(ti[f], q)) begin tag = "R3"; return 0; end
    end
    if (na && ld && !st) begin tag = "R5"; return 1; end
    for (int e = 0; e < 4; e++)
      if (tv[e] && k_st(tk[e]) && older(ti[e], q)) begin tag = "R4"; return 0; end
    if (st)
      for (int e = 0; e < 4; e++)
        if (tv[e] && k_ld(tk[e]) && older(ti[e], q)) begin tag = "R6"; return 0; end
    return 1;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic dispatch(bit [7:0] idx, int k);
    disp_valid = 1'b1; disp_idx = idx;
    disp_ld = k_ld(k); disp_st = k_st(k); disp_lbar = k_lb(k); disp_sbar = k_sb(k);
    step();
    disp_valid = 1'b0;
  endtask

  task automatic complete(bit [7:0] idx);
    cmpl_valid = 1'b1; cmpl_idx = idx;
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic query(bit [7:0] idx, bit ld, bit st, bit na, string ctx);
    string tag;
    bit exp;
    q_idx = idx; q_ld = ld; q_st = st; bypass_mode = na;
    #1;
    exp = expect_ready(idx, ld, st, na, tag);
    check(tag, q_ready, exp, $sformatf("%s q=%0d ld=%0b st=%0b bypass=%0b", ctx, idx, ld, st, na));
  endtask

  task automatic run_mix(int n, int code, bit [7:0] base);
    int c;
    bit [7:0] fresh;
    bit wraps;
    c = code;
    for (int e = 0; e < 4; e++) tv[e] = 0;
    for (int e = 0; e < n; e++) begin
      tv[e] = 1; ti[e] = base + 8'(e); tk[e] = c % 6; c = c / 6;
      dispatch(ti[e], tk[e]);
    end
    fresh = base + 8'(n);
    // R9: mixes whose indices cross 255 -> 0 exercise modular age order
    wraps = (int'(base) + n) > 255;
    for (int na = 0; na < 2; na++) begin
      for (int e = 0; e < n; e++)
        query(ti[e], k_ld(tk[e]), k_st(tk[e]), 1'(na), wraps ? "R9 own" : "own");
      for (int f = 0; f < 4; f++)
        query(fresh, 1'(f & 1), 1'(f >> 1), 1'(na), wraps ? "R9 fresh" : "fresh");
    end
    for (int e = 0; e < n; e++) begin
      complete(ti[e]);
      tv[e] = 0;
    end
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    string tg;
    int scen;
    for (int e = 0; e < 4; e++) tv[e] = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R10: empty after reset
    check("R10", disp_full, 1'b0, "full after reset");
    q_idx = 8'd9; q_ld = 1; q_st = 1; bypass_mode = 0; #1;
    check("R10", q_ready, 1'b1, "ld+st query after reset");

    // main sweep R1..R6, R9
    scen = 0;
    for (int n = 1; n <= 3; n++) begin
      int combos;
      combos = (n == 1) ? 6 : (n == 2) ? 36 : 216;
      for (int code = 0; code < combos; code++) begin
        run_mix(n, code, 8'((scen * 53 + 250) % 256));
        scen++;
      end
    end

    // R9 explicit: store at 254, load at 1
    tv[0] = 1; ti[0] = 8'd254; tk[0] = 2;
    dispatch(8'd254, 2);
    q_idx = 8'd1; q_ld = 1; q_st = 0; bypass_mode = 0; #1;
    check("R9", q_ready, 1'b0, "load 1 behind store 254");
    q_idx = 8'd250; #1;
    check("R9", q_ready, 1'b1, "load 250 ahead of store 254");

    // R8: absent completion ignored
    complete(8'd77);
    q_idx = 8'd1; #1;
    check("R8", q_ready, 1'b0, "store still blocks after absent completion");
    check("R8", disp_full, 1'b0, "full unchanged after absent completion");
    complete(8'd254); tv[0] = 0;
    #1;
    check("R8", q_ready, 1'b1, "load free after real completion");

    // R7: fill with plain ops, then offer a load barrier while full
    for (int e = 0; e < NE; e++) begin
      check("R7", disp_full, 1'b0, "not full before slot fill");
      dispatch(8'(10 + e), 0);
    end
    check("R7", disp_full, 1'b1, "full when all slots taken");
    dispatch(8'd20, 4);
    q_idx = 8'd21; q_ld = 1; q_st = 0; bypass_mode = 0; #1;
    check("R7", q_ready, 1'b1, "barrier offered while full was dropped");
    check("R7", disp_full, 1'b1, "still full after dropped dispatch");
    complete(8'd11);
    check("R7", disp_full, 1'b0, "full drops after completion");
    dispatch(8'd22, 4);
    q_idx = 8'd23; #1;
    check("R2", q_ready, 1'b0, "load behind accepted barrier");
    check("R7", disp_full, 1'b1, "full again after refill");
    q_ld = 0; q_st = 0; #1;
    check("R1", q_ready, 1'b1, "non-memory query ready");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule